// File: doc/BRIEF.md
# Single-Step Shift and Sign-Extend Unit

This unit takes one 32-bit operand and either moves it right by exactly one bit or widens its low byte or low halfword to a full signed word. The right shift comes in three kinds. The arithmetic kind keeps the sign bit. The logical kind clears the top bit. The third kind rotates through the carry flag: the flag's old value enters at the top. Every shift kind drops the bit that leaves the bottom into the carry flag.

The carry flag is the only state in the unit, and it is held inside. Its current value is brought out on `flag_o` so the datapath can read it. Each operation arrives as one beat on a valid/ready input and leaves, in the same cycle, as one beat on a valid/ready output. The unit holds no storage for beats. A beat transfers when `in_valid` and `out_ready` are both high. `in_ready` follows `out_ready` directly, so back-pressure from downstream passes straight through to the source. The carry flag changes only on a transfer.

Top module: `shx_unit`

## Requirements
- R1: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle; a transfer is a cycle in which `in_valid` and `out_ready` are both high.
- R2: With `fn` = 3'b000 (arithmetic shift), `res_o` is `a_i` shifted right by one with bit 31 copied from `a_i[31]`, and `carry_new_o` is `a_i[0]`.
- R3: With `fn` = 3'b001 (logical shift), `res_o` is `a_i` shifted right by one with bit 31 forced to 0, and `carry_new_o` is `a_i[0]`.
- R4: With `fn` = 3'b010 (shift through carry), `res_o` is `a_i` shifted right by one with bit 31 equal to `flag_o` as it stands in that cycle, before the update; `carry_new_o` is `a_i[0]`.
- R5: On a transfer with any of the three shift codes, `carry_we_o` is high and `flag_o` equals `a_i[0]` from the next cycle on.
- R6: With `fn` = 3'b100, `res_o[7:0]` is `a_i[7:0]` and bits 31:8 all equal `a_i[7]`.
- R7: With `fn` = 3'b101, `res_o[15:0]` is `a_i[15:0]` and bits 31:16 all equal `a_i[15]`.
- R8: The sign-extend codes and the reserved codes (3'b011, 3'b110, 3'b111) keep `carry_we_o` low, drive `carry_new_o` with the current `flag_o`, and leave `flag_o` unchanged.
- R9: Each reserved code passes `a_i` to `res_o` unchanged.
- R10: In a cycle with no transfer, `carry_we_o` is low and `flag_o` keeps its value into the next cycle.
- R11: After reset, `flag_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation beat present |
| in_ready | output | 1 | Unit can take the beat |
| a_i | input | 32 | Operand |
| fn_i | input | 3 | Function select |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream takes the result |
| res_o | output | 32 | Result word |
| carry_new_o | output | 1 | Carry value this operation produces |
| carry_we_o | output | 1 | The operation writes the carry flag on this transfer |
| flag_o | output | 1 | Current carry flag |

## Verification
The assertions assume that `fn_i` and `a_i` hold known values whenever `in_valid` is high. They also assume that the carry update depends only on the handshake, so a source may leave a beat waiting while `out_ready` is low. The stimulus changes inputs only on the falling clock edge. It mixes every function code, including the reserved ones, with random operands. It drives valid and ready independently, so stalled beats and idle cycles occur next to transfers. Directed beats first set the flag to 1 and then run the through-carry shift, so both values of the incoming top bit are covered.

// File: rtl/shx_pkg.sv
package shx_pkg;
  localparam int unsigned FN_W = 3;

  typedef enum logic [FN_W-1:0] {
    FN_SHR_ARITH = 3'b000,
    FN_SHR_LOGIC = 3'b001,
    FN_SHR_ROTC  = 3'b010,
    FN_EXT_BYTE  = 3'b100,
    FN_EXT_HALF  = 3'b101
  } shx_fn_e;

  typedef enum logic [1:0] {
    FILL_SIGN = 2'd0,
    FILL_ZERO = 2'd1,
    FILL_FLAG = 2'd2
  } shx_fill_e;
endpackage

// File: rtl/shx_shift1.sv
module shx_shift1 #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]        a,
  input  shx_pkg::shx_fill_e  fill,
  input  logic                cin,
  output logic [W-1:0]        res,
  output logic                cout
);
  logic top_bit;

  always_comb begin
    case (fill)
      shx_pkg::FILL_SIGN: top_bit = a[W-1];
      shx_pkg::FILL_FLAG: top_bit = cin;
      default:            top_bit = 1'b0;
    endcase
  end

  assign res  = {top_bit, a[W-1:1]};
  assign cout = a[0];
endmodule

// File: rtl/shx_sext.sv
module shx_sext #(
  parameter int unsigned W    = 32,
  parameter int unsigned FROM = 8
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] res
);
  localparam int unsigned EXT_W = W - FROM;

  assign res = {{EXT_W{a[FROM-1]}}, a[FROM-1:0]};
endmodule

// File: rtl/shx_flag.sv
module shx_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST_VAL;
    else if (we) q <= d;
  end
endmodule

// File: rtl/shx_unit.sv
module shx_unit #(
  parameter int unsigned W      = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned HALF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [W-1:0]             a_i,
  input  logic [shx_pkg::FN_W-1:0] fn_i,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [W-1:0]             res_o,
  output logic                     carry_new_o,
  output logic                     carry_we_o,
  output logic                     flag_o
);
  import shx_pkg::*;

  localparam int unsigned N_EXT = 2;

  logic              xfer;
  logic              is_shift;
  shx_fill_e         fill;
  logic [W-1:0]      sh_res;
  logic              sh_cout;
  logic [W-1:0]      ext_res [N_EXT];
  logic              flag_q;

  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign xfer      = in_valid && out_ready;

  always_comb begin
    is_shift = 1'b1;
    fill     = FILL_SIGN;
    case (fn_i)
      FN_SHR_ARITH: fill = FILL_SIGN;
      FN_SHR_LOGIC: fill = FILL_ZERO;
      FN_SHR_ROTC:  fill = FILL_FLAG;
      default:      is_shift = 1'b0;
    endcase
  end

  shx_shift1 #(.W(W)) u_shift (
    .a    (a_i),
    .fill (fill),
    .cin  (flag_q),
    .res  (sh_res),
    .cout (sh_cout)
  );

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    localparam int unsigned FROM = (g == 0) ? BYTE_W : HALF_W;
    shx_sext #(.W(W), .FROM(FROM)) u_sext (
      .a   (a_i),
      .res (ext_res[g])
    );
  end

  always_comb begin
    case (fn_i)
      FN_SHR_ARITH, FN_SHR_LOGIC, FN_SHR_ROTC: res_o = sh_res;
      FN_EXT_BYTE: res_o = ext_res[0];
      FN_EXT_HALF: res_o = ext_res[1];
      default:     res_o = a_i;
    endcase
  end

  assign carry_new_o = is_shift ? sh_cout : flag_q;
  assign carry_we_o  = xfer && is_shift;

  shx_flag #(.RST_VAL(1'b0)) u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (carry_we_o),
    .d     (carry_new_o),
    .q     (flag_q)
  );

  assign flag_o = flag_q;

  // Assertions
  assert_handshake_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (in_ready == out_ready));

  assert_shift_body_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i inside {3'b000, 3'b001, 3'b010}) |->
      (res_o[W-2:0] == a_i[W-1:1]) && (carry_new_o == a_i[0]));

  assert_rotc_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i == 3'b010) |-> (res_o[W-1] == flag_o));

  assert_flag_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_ready && (fn_i inside {3'b000, 3'b001, 3'b010}))
      |=> (flag_o == $past(a_i[0])));

  assert_no_flag_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fn_i inside {3'b000, 3'b001, 3'b010}) |=> $stable(flag_o));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && out_ready) |=> $stable(flag_o));

  assert_stall_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && out_ready) |-> !carry_we_o);
endmodule

// File: tb/sim_shx_unit.sv
module sim_shx_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] a_i = '0;
  logic [2:0]  fn_i = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] res_o;
  logic        carry_new_o;
  logic        carry_we_o;
  logic        flag_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit model_flag = 1'b0;

  always #2 clk = ~clk;

  shx_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_i(a_i), .fn_i(fn_i), .out_valid(out_valid), .out_ready(out_ready),
    .res_o(res_o), .carry_new_o(carry_new_o), .carry_we_o(carry_we_o),
    .flag_o(flag_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] f);
    case (f)
      3'b000: return "R2";
      3'b001: return "R3";
      3'b010: return "R4";
      3'b100: return "R6";
      3'b101: return "R7";
      default: return "R9";
    endcase
  endfunction

  // One cycle: drive at falling edge, compare against model, update model at rising edge.
  task automatic step(input logic [2:0] f, input logic [31:0] a, input bit v, input bit r);
    logic [31:0] e_res;
    bit e_cnew, e_we, sh, xf;
    @(negedge clk);
    fn_i = f; a_i = a; in_valid = v; out_ready = r;
    #1;
    check("R5", "flag before beat", {31'd0, flag_o}, {31'd0, model_flag});
    sh = (f == 3'b000) || (f == 3'b001) || (f == 3'b010);
    xf = v && r;
    case (f)
      3'b000:  e_res = $unsigned($signed(a) >>> 1);
      3'b001:  e_res = a >> 1;
      3'b010:  e_res = (a >> 1) | (32'(model_flag) << 31);
      3'b100:  e_res = 32'($signed(a[7:0]));
      3'b101:  e_res = 32'($signed(a[15:0]));
      default: e_res = a;
    endcase
    e_cnew = sh ? a[0] : model_flag;
    e_we   = sh && xf;
    check(req_of(f), "result", res_o, e_res);
    check(sh ? "R5" : "R8", "carry_new", {31'd0, carry_new_o}, {31'd0, e_cnew});
    check(xf ? (sh ? "R5" : "R8") : "R10", "carry_we", {31'd0, carry_we_o}, {31'd0, e_we});
    check("R1", "handshake", {30'd0, out_valid, in_ready}, {30'd0, v, r});
    @(posedge clk);
    if (e_we) model_flag = a[0];
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R11", "flag after reset", {31'd0, flag_o}, 32'd0);

    step(3'b000, 32'h8000_0003, 1, 1);   // R2 sign kept, carry 1
    step(3'b010, 32'h0000_0010, 1, 1);   // R4 old flag 1 enters top
    step(3'b010, 32'hFFFF_FFFE, 1, 1);   // R4 old flag 0 enters top
    step(3'b001, 32'hFFFF_FFFF, 1, 1);   // R3 top cleared, flag to 1
    step(3'b100, 32'h1234_5680, 1, 1);   // R6 negative byte, R8 flag kept
    step(3'b101, 32'hABCD_7FFF, 1, 1);   // R7 positive halfword
    step(3'b101, 32'h0000_8001, 1, 1);   // R7 negative halfword
    step(3'b011, 32'hDEAD_BEEF, 1, 1);   // R9 reserved passthrough
    step(3'b000, 32'h0000_0002, 1, 0);   // R10 stalled shift, flag stays 1
    step(3'b000, 32'h0000_0002, 0, 1);   // R10 idle
    step(3'b010, 32'h0000_0000, 1, 1);   // R4 flag 1 into top, flag to 0
    step(3'b111, 32'h0F0F_0F0F, 1, 1);   // R9
    step(3'b110, 32'h0000_0001, 1, 1);   // R9 / R8

    for (int i = 0; i < 3000; i++)
      step(3'($urandom_range(0, 7)), $urandom, 1'($urandom), 1'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule